// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable, reduced-depth model of a single-clock static RAM with a pipelined read path and a built-in burst sequencer. Every input is sampled on the rising clock edge. These inputs are the address, write data, three chip enables, two address strobes, a burst-advance input, a global write, a byte-write enable and four byte strobes. A new address can be loaded by either strobe. After that, a 2-bit counter generates the rest of a four-word burst. The burst runs in linear or interleaved order, selected by `mode`.

A read returns its word through an output register, so data appear two rising edges after the address is taken. Writes are byte-granular, and a global write overrides the byte strobes. When the block is deselected, the output drive is withdrawn one cycle after the deselect is taken. The output enable gates the drive without a clock. The data bus is split into a write port and a read port, and `rdata_en` marks the cycles in which the read port would drive the shared bus. All control inputs are active low. `mode` and the clock are the exceptions.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and until the first access after reset has run through the pipeline, `rdata_en` is 0.
- R2: The word read by an access captured at rising edge k is on `rdata`, with `rdata_en` high, after edge k+1, provided `oe_n` is low.
- R3: With `mode` = 0, each advance (`adv_n` low, no strobe loading) moves the low two address bits to (loaded low bits + count) mod 4, where count is the number of advances. The upper bits stay as loaded, so from low bits 01 the order is 01, 10, 11, 00, then 01 again.
- R4: With `mode` = 1, the low two address bits are the loaded low bits XOR the count, so from low bits 10 the order is 10, 11, 00, 01.
- R5: While the block is selected and neither strobe loads, `adv_n` high repeats the access at the current burst address.
- R6: `gw_n` low writes all four bytes of the accessed word, whatever `bwe_n` and `bw_n` are. A write cycle does not raise `rdata_en` for that access.
- R7: With `gw_n` high, a write happens only when `bwe_n` is low. Byte lane i (bits 8i+7..8i) changes only when `bw_n[i]` is low. With `bwe_n` high, the cycle is a read, whatever the strobes are.
- R8: `adsp_n` low is ignored when the chip enables sampled at the same edge do not select the block. In that case a running burst continues as if the strobe were high. `adsc_n` low always loads the address.
- R9: A strobe load with the block not selected ends the burst. `rdata_en` falls after the next rising edge, and the data of the access captured one edge before the deselect are still delivered.
- R10: `oe_n` high forces `rdata_en` low and `rdata` to zero within the same cycle, without waiting for a clock edge.
- R11: The block is selected only when all three of `ce_a_n`, `ce_b_n` and `ce_c_n` are low. Any one of them high at a strobe load deselects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low (memory contents kept) |
| addr | input | AW | External word address |
| wdata | input | DW | Write data |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b_n | input | 1 | Chip enable B, active low |
| ce_c_n | input | 1 | Chip enable C, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low, qualified by the enables |
| adsc_n | input | 1 | Controller-side address strobe, active low, always loads |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all bytes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | DW/8 | Per-byte write strobes, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| rdata | output | DW | Read data from the output register, zero when not driven |
| rdata_en | output | 1 | High when the read port drives the bus |

## Verification
The hardest case to reach from the ports is a processor strobe that arrives in the middle of a running burst while one chip enable is high. The correct result is an ordinary advance, and no new load or deselect may occur. The stimulus builds this case directly: it starts a burst with the controller strobe, then raises one enable in the same cycle as the processor strobe and the advance. The scoreboard then expects the next word of the burst and the old upper address bits. Burst wrap, suspends between advances, and a mode switch between bursts are reached in the same way. Each one runs from a base address whose low bits are not zero.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ce_a_n,
  input  logic          ce_b_n,
  input  logic          ce_c_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic          mode,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_en
);

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          act;

  logic [AW-1:0] a1;
  logic          v1;
  logic [NB-1:0] we1;
  logic [DW-1:0] d1;

  logic [DW-1:0] q;
  logic          vq;

  logic          sel, load, acc_v;
  logic [1:0]    cnt_nx, lo;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] we_now;

  assign sel      = !ce_a_n && !ce_b_n && !ce_c_n;
  assign load     = !adsc_n || (!adsp_n && sel);
  assign cnt_nx   = (!load && !adv_n) ? cnt + 2'd1 : cnt;
  assign lo       = mode ? (base[1:0] ^ cnt_nx) : (base[1:0] + cnt_nx);
  assign acc_addr = load ? addr : {base[AW-1:2], lo};
  assign acc_v    = load ? sel : act;
  assign we_now   = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
      act  <= 1'b0;
      a1   <= '0;
      v1   <= 1'b0;
      we1  <= '0;
      d1   <= '0;
      vq   <= 1'b0;
      q    <= '0;
    end else begin
      if (load) begin
        base <= addr;
        cnt  <= '0;
        act  <= sel;
      end else begin
        cnt  <= cnt_nx;
      end
      a1  <= acc_addr;
      v1  <= acc_v;
      we1 <= we_now;
      d1  <= wdata;
      vq  <= v1 && (we1 == '0);
      if (v1 && (we1 == '0)) q <= mem[a1];
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (v1 && we1[b]) mem[a1][b*8 +: 8] <= d1[b*8 +: 8];
  end

  assign rdata_en = vq && !oe_n;
  assign rdata    = rdata_en ? q : '0;

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && sel && gw_n && bwe_n) |=> ##1 vq);

  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && adsc_n && adsp_n && adv_n && $stable(mode)) |=> $stable(a1));

  assert_write_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && acc_v) |=> ##1 !vq);

  assert_adsp_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && !adsp_n && !sel) |=> $stable(base));

  assert_deselect_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && !sel) |=> ##1 !vq);

endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/100ps
module burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ce_a_n, ce_b_n, ce_c_n;
  logic          adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [NB-1:0] bw_n;
  logic          mode, oe_n;
  logic [DW-1:0] rdata;
  logic          rdata_en;

  burst_sram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c_n(ce_c_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .mode(mode), .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [DW:0] sbq [$];
  string       tq  [$];

  logic [DW-1:0] rmem [1<<AW];
  logic [AW-1:0] m_base, m_a1;
  logic [1:0]    m_cnt;
  logic          m_act, m_v1, m_vq;
  logic [NB-1:0] m_we1;
  logic [DW-1:0] m_d1, m_q;

  task automatic tick();
    logic sel, load, acc;
    logic [AW-1:0] ad;
    logic [1:0] lo;
    logic [NB-1:0] we;
    sbq.push_back({m_vq && !oe_n, (m_vq && !oe_n) ? m_q : 32'h0});
    tq.push_back(tag);
    sel  = !ce_a_n && !ce_b_n && !ce_c_n;
    load = !adsc_n || (!adsp_n && sel);
    if (load) begin
      acc = sel; ad = addr; m_base = addr; m_cnt = 0; m_act = sel;
    end else begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      lo  = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ad  = {m_base[AW-1:2], lo};
      acc = m_act;
    end
    we = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
    if (m_v1)
      for (int b = 0; b < NB; b++)
        if (m_we1[b]) rmem[m_a1][b*8 +: 8] = m_d1[b*8 +: 8];
    m_vq = m_v1 && (m_we1 == 0);
    if (m_vq) m_q = rmem[m_a1];
    m_v1 = acc; m_a1 = ad; m_we1 = we; m_d1 = wdata;
    @(negedge clk);
  endtask

  task automatic defaults();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    ce_a_n = 0; ce_b_n = 0; ce_c_n = 0; oe_n = 0; wdata = 0;
  endtask

  task automatic cyc(input logic sc, input logic sp, input logic av,
                     input logic g, input logic be, input logic [3:0] bw,
                     input logic [2:0] ce, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    adsc_n = sc; adsp_n = sp; adv_n = av; gw_n = g; bwe_n = be; bw_n = bw;
    {ce_c_n, ce_b_n, ce_a_n} = ce; addr = a; wdata = d;
    tick();
    defaults();
  endtask

  task automatic rd_load(input logic [AW-1:0] a);
    cyc(0, 1, 1, 1, 1, 4'hF, 3'b000, a, 0);
  endtask
  task automatic adv();
    cyc(1, 1, 0, 1, 1, 4'hF, 3'b000, 0, 0);
  endtask
  task automatic hold();
    cyc(1, 1, 1, 1, 1, 4'hF, 3'b000, 0, 0);
  endtask
  task automatic desel();
    cyc(0, 1, 1, 1, 1, 4'hF, 3'b001, 0, 0);
  endtask

  initial begin : monitor
    logic [DW:0] e;
    string t;
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        t = tq.pop_front();
        checks++;
        if (rdata_en !== e[DW] || rdata !== e[DW-1:0]) begin
          errors++;
          $display("FAIL %s: en=%b data=%h expected en=%b data=%h",
                   t, rdata_en, rdata, e[DW], e[DW-1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    mode = 0; addr = 0; rst_n = 0;
    m_base = 0; m_a1 = 0; m_cnt = 0; m_act = 0; m_v1 = 0; m_vq = 0;
    m_we1 = 0; m_d1 = 0; m_q = 0;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (rdata_en !== 1'b0) begin
      errors++;
      $display("FAIL R1: en=%b expected 0", rdata_en);
    end
    @(negedge clk);
    rst_n = 1;
    tag = "R1";
    hold(); hold(); rd_load(0); hold();

    tag = "R6";
    for (int a = 0; a < (1 << AW); a++)
      cyc(0, 1, 1, 0, 1, 4'hF, 3'b000, a[AW-1:0], (a * 32'h01030507) ^ 32'hA5C3_0F00);
    desel();

    tag = "R2";
    rd_load(5); desel(); hold(); rd_load(6); rd_load(7); desel(); hold();

    tag = "R3";
    mode = 0;
    rd_load(6'h0D); adv(); adv(); adv(); adv(); desel();

    tag = "R5";
    cyc(1, 0, 1, 1, 1, 4'hF, 3'b000, 6'h21, 0);
    adv(); hold(); hold(); adv(); desel();

    tag = "R4";
    mode = 1;
    rd_load(6'h0E); adv(); adv(); adv(); desel();
    mode = 0;

    tag = "R7";
    cyc(0, 1, 1, 1, 0, 4'b1010, 3'b000, 6'h12, 32'hDEADBEEF);
    cyc(0, 1, 1, 1, 1, 4'b0000, 3'b000, 6'h13, 32'h11223344);
    desel();
    rd_load(6'h12); rd_load(6'h13); desel();

    tag = "R6";
    cyc(0, 1, 1, 0, 0, 4'b1110, 3'b000, 6'h14, 32'hCAFEF00D);
    desel(); rd_load(6'h14); desel();

    tag = "R8";
    rd_load(6'h30);
    cyc(1, 0, 0, 1, 1, 4'hF, 3'b001, 6'h08, 0);
    adv();
    cyc(1, 0, 1, 1, 1, 4'hF, 3'b000, 6'h08, 0);
    adv();

    tag = "R9";
    desel(); hold(); hold();

    tag = "R11";
    rd_load(6'h22); cyc(0, 1, 1, 1, 1, 4'hF, 3'b010, 0, 0); hold();
    rd_load(6'h23); cyc(0, 1, 1, 1, 1, 4'hF, 3'b100, 0, 0); hold();
    rd_load(6'h24); cyc(0, 1, 1, 1, 1, 4'hF, 3'b001, 0, 0); hold();

    tag = "R10";
    rd_load(6'h28); adv();
    oe_n = 1; adsc_n = 1; adv_n = 0; tick(); defaults();
    adv(); desel(); hold(); hold();

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule